// File: doc/BRIEF.md
# Sixteen-Pin GPIO Bank with Edge Interrupts

The block is one bank of general-purpose pins sitting behind a plain register bus (byte address, write strobe, write word, combinational read word). Every pin carries an output latch, a direction bit and a synchronized input sample. For interrupts, each pin also has a rising/falling edge selector, a blocking bit and a sticky flag. A separate ownership register decides which pins the processor actually controls. Pins it does not own are never driven, read back as zero and cannot raise the interrupt.

Pin inputs pass through a two-flop synchronizer and one history flop. A selected edge sets the pin's flag whether or not the pin is blocked. Software clears flags by writing ones. The single interrupt output is the OR over all owned pins of a set flag that is not blocked.

Top module: `gpio_bank`

Register byte offsets: 0x00 input sample (read-only), 0x04 output latch, 0x08 direction, 0x0C edge select, 0x10 interrupt block, 0x14 interrupt flags, 0x18 ownership. Only the low 16 bits of each word are meaningful. Other addresses read as zero.

## Requirements
- R1: After reset the block register reads 0xFFFF, the direction register reads 0xFFFF, and the flag, output-latch, edge-select and ownership registers read 0. irq is 0 and pin_oe is 0.
- R2: Writes to 0x04, 0x08, 0x0C, 0x10 and 0x18 store the low 16 bits of the word, and those bits read back with the upper 16 bits as zero. A write to 0x00 changes nothing. A register changes only when its own offset is written.
- R3: At 0x00, bit n reads pin_in[n] as it stood two clock edges earlier when pin n is owned (ownership bit 1), and reads 0 when it is not owned.
- R4: A direction bit of 1 means input and 0 means output. pin_oe[n] = ownership[n] AND NOT direction[n], and pin_out carries the output latch.
- R5: An edge-select bit of 1 picks rising edges and 0 picks falling edges. A selected edge on pin_in sets the flag bit on the third clock edge after the pin changes. The other edge direction sets nothing.
- R6: A flag bit is set by its selected edge even while that pin's block bit is 1.
- R7: Writing a word to 0x14 clears the flag bits where the word has ones and leaves the bits where it has zeros.
- R8: When a clearing write and a newly detected selected edge hit the same flag bit in the same cycle, the bit stays set.
- R9: irq is 1 exactly when some pin has its flag set, its block bit 0 and its ownership bit 1.
- R10: A flag stays set after the pin returns to its former level, until software clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Register byte address |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 32 | Write word |
| bus_rdata | output | 32 | Read word of the addressed register, combinational |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_out | output | 16 | Output latch levels |
| pin_oe | output | 16 | Per-pin drive enable |
| irq | output | 1 | Combined interrupt |

## Verification
Register writes take effect on the first clock edge. Reads are combinational, so the bench samples them a little after the following falling edge. A pin change driven at a falling edge appears at offset 0x00 after two rising edges and in the flag register after three, and irq follows the flag with no added cycle. The bench waits exactly those counts before queuing each expectation, and also checks one cycle short of each latency to show the delay is not shorter. For the collision case, the clearing write is placed so that its strobe is sampled on the same edge that captures the new edge.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    typedef enum logic [2:0] {
        SEL_SAMPLE = 3'd0,
        SEL_DRIVE  = 3'd1,
        SEL_DIR    = 3'd2,
        SEL_RISE   = 3'd3,
        SEL_BLOCK  = 3'd4,
        SEL_FLAG   = 3'd5,
        SEL_OWN    = 3'd6,
        SEL_NONE   = 3'd7
    } reg_sel_e;

    localparam logic [7:0] OFS_DRIVE = 8'h04;
    localparam logic [7:0] OFS_BLOCK = 8'h10;
    localparam logic [7:0] OFS_FLAG  = 8'h14;

endpackage

// File: rtl/gpio_reg_decode.sv
module gpio_reg_decode
    import gpio_bank_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] addr,
    output reg_sel_e      sel
);
    localparam int LAST_IDX = 6;

    logic [AW-1:0] word_idx;

    always_comb begin
        word_idx = addr >> 2;
        if (addr[1:0] == 2'b00 && word_idx <= AW'(LAST_IDX))
            sel = reg_sel_e'(word_idx[2:0]);
        else
            sel = SEL_NONE;
    end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] cur_q,
    output logic [W-1:0] prev_q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            cur_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= raw;
            cur_q  <= meta_q;
            prev_q <= cur_q;
        end
    end
endmodule

// File: rtl/gpio_edge_pick.sv
module gpio_edge_pick #(
    parameter int W = 16
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] prev,
    input  logic [W-1:0] rise_sel,
    output logic [W-1:0] hit
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        logic up, down;
        assign up     = cur[i] & ~prev[i];
        assign down   = ~cur[i] & prev[i];
        assign hit[i] = rise_sel[i] ? up : down;
    end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 16,
    parameter int AW    = 5,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_we,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe,
    output logic             irq
);
    localparam int PAD = DW - NPINS;

    typedef struct packed {
        logic [NPINS-1:0] drive;
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] rise;
        logic [NPINS-1:0] block;
        logic [NPINS-1:0] flag;
        logic [NPINS-1:0] own;
    } bank_t;

    bank_t            st_d, st_q;
    reg_sel_e         sel;
    logic [NPINS-1:0] sync_cur, sync_prev, edge_hit, wr_bits, clr_bits, rd_bits;
    logic             unused_hi;

    assign wr_bits   = bus_wdata[NPINS-1:0];
    assign unused_hi = ^bus_wdata[DW-1:NPINS];

    gpio_reg_decode #(.AW(AW)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    gpio_sync #(.W(NPINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (pin_in),
        .cur_q  (sync_cur),
        .prev_q (sync_prev)
    );

    gpio_edge_pick #(.W(NPINS)) u_edge (
        .cur      (sync_cur),
        .prev     (sync_prev),
        .rise_sel (st_q.rise),
        .hit      (edge_hit)
    );

    always_comb begin
        st_d     = st_q;
        clr_bits = '0;
        if (bus_we) begin
            unique case (sel)
                SEL_DRIVE: st_d.drive = wr_bits;
                SEL_DIR:   st_d.dir   = wr_bits;
                SEL_RISE:  st_d.rise  = wr_bits;
                SEL_BLOCK: st_d.block = wr_bits;
                SEL_FLAG:  clr_bits   = wr_bits;
                SEL_OWN:   st_d.own   = wr_bits;
                default:   ;
            endcase
        end
        // a fresh edge overrides a simultaneous clear
        st_d.flag = (st_q.flag & ~clr_bits) | edge_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.drive <= '0;
            st_q.dir   <= '1;
            st_q.rise  <= '0;
            st_q.block <= '1;
            st_q.flag  <= '0;
            st_q.own   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_SAMPLE: rd_bits = sync_cur & st_q.own;
            SEL_DRIVE:  rd_bits = st_q.drive;
            SEL_DIR:    rd_bits = st_q.dir;
            SEL_RISE:   rd_bits = st_q.rise;
            SEL_BLOCK:  rd_bits = st_q.block;
            SEL_FLAG:   rd_bits = st_q.flag;
            SEL_OWN:    rd_bits = st_q.own;
            default:    rd_bits = '0;
        endcase
    end

    assign bus_rdata = {{PAD{1'b0}}, rd_bits};
    assign pin_out   = st_q.drive;
    assign pin_oe    = st_q.own & ~st_q.dir;
    assign irq       = |(st_q.flag & ~st_q.block & st_q.own);
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 16,
    parameter int AW    = 5,
    parameter int DW    = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [AW-1:0]    bus_addr,
    input logic             bus_we,
    input logic [DW-1:0]    bus_wdata,
    input logic [NPINS-1:0] pin_oe,
    input logic             irq,
    input logic [NPINS-1:0] sync_cur,
    input logic [NPINS-1:0] sync_prev,
    input logic [NPINS-1:0] flag_q,
    input logic [NPINS-1:0] block_q,
    input logic [NPINS-1:0] own_q,
    input logic [NPINS-1:0] dir_q
);
    a_r5_flag_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_q & ~$past(flag_q) & ~$past(sync_cur ^ sync_prev)) == '0));

    a_r7_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_FLAG[AW-1:0]) |=>
        ((flag_q & $past(bus_wdata[NPINS-1:0]) & ~$past(sync_cur ^ sync_prev)) == '0));

    a_r2_block_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == OFS_BLOCK[AW-1:0]) |=> $stable(block_q));

    a_r4_drive_only_owned_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe & (~own_q | dir_q)) == '0));

    a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag_q != '0));

    a_r9_all_blocked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (block_q == '1) |-> !irq);
endmodule

bind gpio_bank gpio_bank_chk #(.NPINS(NPINS), .AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .sync_cur  (sync_cur),
    .sync_prev (sync_prev),
    .flag_q    (st_q.flag),
    .block_q   (st_q.block),
    .own_q     (st_q.own),
    .dir_q     (st_q.dir)
);

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out, pin_oe;
    logic        irq;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        int          what;   // 0 rdata, 1 irq, 2 pin_oe, 3 pin_out
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #4 clk = ~clk;

    gpio_bank dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic expect_q(input int what, input logic [4:0] a,
                            input logic [31:0] e, input string tag);
        item_t it;
        bus_addr = a;
        it.what = what; it.exp = e; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] e, input string tag);
        expect_q(0, a, e, tag);
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: compares one queued item a little after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (sb.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb.pop_front();
                case (it.what)
                    0: act = bus_rdata;
                    1: act = {31'd0, irq};
                    2: act = {16'd0, pin_oe};
                    default: act = {16'd0, pin_out};
                endcase
                n_checks++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        settle(3);
        rst_n = 1'b1;
        settle(1);

        // R1 reset values
        rd(5'h10, 32'h0000FFFF, "R1 block");
        rd(5'h14, 32'h0, "R1 flags");
        rd(5'h08, 32'h0000FFFF, "R1 dir");
        rd(5'h18, 32'h0, "R1 own");
        rd(5'h04, 32'h0, "R1 drive");
        rd(5'h0C, 32'h0, "R1 edge");
        expect_q(1, 5'h0, 32'h0, "R1 irq");
        expect_q(2, 5'h0, 32'h0, "R1 oe");

        // R2 register storage
        wr(5'h04, 32'hFFFFA5A5);
        wr(5'h08, 32'h00000F0F);
        wr(5'h18, 32'h0000FFFF);
        rd(5'h04, 32'h0000A5A5, "R2 drive upper dropped");
        rd(5'h08, 32'h00000F0F, "R2 dir");
        rd(5'h18, 32'h0000FFFF, "R2 own");
        rd(5'h10, 32'h0000FFFF, "R2 block untouched");
        wr(5'h00, 32'hFFFFFFFF);
        rd(5'h00, 32'h0, "R2 input write ignored");
        rd(5'h1C, 32'h0, "R2 unmapped reads zero");

        // R4 drive enables
        expect_q(2, 5'h0, 32'h0000F0F0, "R4 oe owned outputs");
        expect_q(3, 5'h0, 32'h0000A5A5, "R4 pin_out");
        wr(5'h18, 32'h000000FF);
        expect_q(2, 5'h0, 32'h000000F0, "R4 oe after ownership drop");

        // R3 input sampling latency and ownership gating
        pin_in = 16'hFFFF;
        settle(1);
        rd(5'h00, 32'h0, "R3 not yet visible");
        rd(5'h00, 32'h000000FF, "R3 owned bits only");
        rd(5'h14, 32'h0, "R5 rising ignored on falling select");

        // R5 rising select on pin 0, blocked (R6)
        wr(5'h0C, 32'h00000001);
        pin_in = 16'hFFFE;
        settle(3);
        rd(5'h14, 32'h0, "R5 falling ignored on rising select");
        pin_in = 16'hFFFF;
        settle(2);
        rd(5'h14, 32'h0, "R5 not before third edge");
        rd(5'h14, 32'h00000001, "R5 R6 rising sets flag while blocked");
        expect_q(1, 5'h0, 32'h0, "R9 blocked quiet");

        // R5 falling on pin 1
        pin_in = 16'hFFFD;
        settle(3);
        rd(5'h14, 32'h00000003, "R5 falling sets flag");

        // R9 combining
        wr(5'h10, 32'h0000FFFE);
        expect_q(1, 5'h0, 32'h1, "R9 unblocked flag raises irq");
        wr(5'h18, 32'h000000FC);
        expect_q(1, 5'h0, 32'h0, "R9 unowned pin quiet");
        wr(5'h18, 32'h000000FF);
        expect_q(1, 5'h0, 32'h1, "R9 ownership restored");

        // R7 write-one-to-clear
        wr(5'h14, 32'h00000001);
        rd(5'h14, 32'h00000002, "R7 clear one bit only");
        expect_q(1, 5'h0, 32'h0, "R9 irq drops after clear");

        // R8 clear and edge together
        pin_in = 16'hFFFC;
        settle(3);
        rd(5'h14, 32'h00000002, "R5 fall on rising-select pin");
        pin_in = 16'hFFFD;
        settle(2);
        wr(5'h14, 32'h00000001);
        rd(5'h14, 32'h00000003, "R8 edge beats clear");

        // R10 sticky
        pin_in = 16'hFFFF;
        settle(3);
        rd(5'h14, 32'h00000003, "R10 flags stay set");
        wr(5'h14, 32'h00000003);
        rd(5'h14, 32'h0, "R7 clear both");
        expect_q(1, 5'h0, 32'h0, "R9 quiet after clear");

        settle(2);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule